// File: doc/BRIEF.md
# Multi-Master Hardware Mutex

This block lets several processors that share a memory-mapped bus agree on which of them owns a shared resource, such as a message buffer in shared memory. A processor claims the lock with one write that carries its own identifier and a nonzero tag value. The hardware grants the claim only if the lock is free or already belongs to that identifier, so no read-modify-write race can occur. Any processor can then read the lock word back to see whether its own identifier was recorded.

The owner keeps the lock until it writes a zero tag under its own identifier. Writes from any other identifier leave the lock untouched. A sticky flag tells software that the block has come out of reset since the flag was last acknowledged. Each master port has its own write strobe, word select, write data and read data. Reads are combinational from the stored state, and every port sees the same state.

Top module: `hwmutex_top`

## Requirements
- R1: After reset the lock word reads zero, which means owner zero, tag zero and free. The sticky reset flag reads 1.
- R2: Word select 0 addresses the lock word, with the owner identifier in bits 31:16 and the tag in bits 15:0. Word select 1 addresses the flag word, with the flag in bit 0 and zeros above it. Every port reads the same state, and a write is visible in the cycle after its clock edge.
- R3: A lock-word write with a nonzero tag while the stored tag is zero stores the written identifier and tag.
- R4: A lock-word write with a nonzero tag while the lock is held under a different identifier is ignored.
- R5: A lock-word write with a nonzero tag from the current owner's identifier replaces the tag and keeps the owner.
- R6: A lock-word write with a zero tag from the current owner's identifier releases the lock, and the whole word reads zero.
- R7: A zero-tag lock-word write from any identifier other than the owner's has no effect. This includes such a write while the lock is free.
- R8: If several ports write the lock word in the same cycle, only the lowest-numbered of them is evaluated and the others are discarded, even if a discarded write would have succeeded on its own.
- R9: Writing the flag word with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. Only reset sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mstWrEn | input | NUM_MASTERS | Per-port write strobe |
| mstAddr | input | NUM_MASTERS | Per-port word select (0 lock word, 1 flag word) |
| mstWrData | input | NUM_MASTERS x 32 | Per-port write data |
| mstRdData | output | NUM_MASTERS x 32 | Per-port read data for the selected word |

## Verification
A wrong owner or tag register shows up on the lock word in the cycle right after the faulty write. It appears as a claim that should have been refused, a release that left a stale owner, or a discarded lower-priority write that took effect. A wrong flag shows up on the flag word right after a clear, or right after a later reset. Because every read is combinational, each fault is visible one clock after its cause, on every port.

// File: rtl/hwmutex_pkg.sv
package hwmutex_pkg;
  localparam int FIELD_W = 16;
  localparam int WORD_W  = 2 * FIELD_W;

  typedef struct packed {
    logic               take;
    logic               drop;
    logic               clrFlag;
    logic [FIELD_W-1:0] nextOwner;
    logic [FIELD_W-1:0] nextTag;
  } mutexStrobes_t;
endpackage

// File: rtl/hwmutex_ctrl.sv
module hwmutex_ctrl
  import hwmutex_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic [NUM_MASTERS-1:0]             wrEn,
  input  logic [NUM_MASTERS-1:0]             addrSel,
  input  logic [NUM_MASTERS-1:0][WORD_W-1:0] wrData,
  input  logic [FIELD_W-1:0]                 curOwner,
  input  logic [FIELD_W-1:0]                 curTag,
  output mutexStrobes_t                      strobes
);
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [NUM_MASTERS-1:0] lockWr;
  logic [NUM_MASTERS-1:0] flagClrReq;

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_req
    assign lockWr[g]     = wrEn[g] & ~addrSel[g];
    assign flagClrReq[g] = wrEn[g] & addrSel[g] & wrData[g][0];
  end

  logic [IDX_W-1:0]   winIdx;
  logic               winHit;
  logic [FIELD_W-1:0] winId;
  logic [FIELD_W-1:0] winTag;
  logic               isFree;
  logic               idMatch;

  always_comb begin
    winIdx = '0;
    winHit = 1'b0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (lockWr[i]) begin
        winIdx = IDX_W'(i);
        winHit = 1'b1;
      end
    end
  end

  assign winId   = wrData[winIdx][WORD_W-1:FIELD_W];
  assign winTag  = wrData[winIdx][FIELD_W-1:0];
  assign isFree  = (curTag == '0);
  assign idMatch = (winId == curOwner);

  always_comb begin
    strobes.take      = winHit && (winTag != '0) && (isFree || idMatch);
    strobes.drop      = winHit && (winTag == '0) && !isFree && idMatch;
    strobes.clrFlag   = |flagClrReq;
    strobes.nextOwner = winId;
    strobes.nextTag   = winTag;
  end
endmodule

// File: rtl/hwmutex_dp.sv
module hwmutex_dp
  import hwmutex_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  mutexStrobes_t                      strobes,
  input  logic [NUM_MASTERS-1:0]             addrSel,
  output logic [FIELD_W-1:0]                 ownerQ,
  output logic [FIELD_W-1:0]                 tagQ,
  output logic                               flagQ,
  output logic [NUM_MASTERS-1:0][WORD_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= '0;
      tagQ   <= '0;
      flagQ  <= 1'b1;
    end else begin
      if (strobes.take) begin
        ownerQ <= strobes.nextOwner;
        tagQ   <= strobes.nextTag;
      end else if (strobes.drop) begin
        ownerQ <= '0;
        tagQ   <= '0;
      end
      if (strobes.clrFlag) flagQ <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_rd
    assign rdData[g] = addrSel[g] ? {{(WORD_W-1){1'b0}}, flagQ} : {ownerQ, tagQ};
  end
endmodule

// File: rtl/hwmutex_top.sv
module hwmutex_top
  import hwmutex_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_MASTERS-1:0]             mstWrEn,
  input  logic [NUM_MASTERS-1:0]             mstAddr,
  input  logic [NUM_MASTERS-1:0][WORD_W-1:0] mstWrData,
  output logic [NUM_MASTERS-1:0][WORD_W-1:0] mstRdData
);
  mutexStrobes_t      strobes;
  logic [FIELD_W-1:0] curOwner;
  logic [FIELD_W-1:0] curTag;
  logic               rstFlag;

  hwmutex_ctrl #(.NUM_MASTERS(NUM_MASTERS)) i_ctrl (
    .wrEn(mstWrEn), .addrSel(mstAddr), .wrData(mstWrData),
    .curOwner(curOwner), .curTag(curTag), .strobes(strobes)
  );

  hwmutex_dp #(.NUM_MASTERS(NUM_MASTERS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrSel(mstAddr),
    .ownerQ(curOwner), .tagQ(curTag), .flagQ(rstFlag), .rdData(mstRdData)
  );
endmodule

// File: rtl/hwmutex_chk.sv
module hwmutex_chk
  import hwmutex_pkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_MASTERS-1:0] mstWrEn,
  input logic [FIELD_W-1:0]     curOwner,
  input logic [FIELD_W-1:0]     curTag,
  input logic                   rstFlag
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (curOwner == '0 && curTag == '0 && rstFlag));

  // R4
  owner_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curTag) != '0 && curTag != '0) |-> curOwner == $past(curOwner));

  // R6
  free_word_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curTag == '0) |-> (curOwner == '0));

  // R9
  flag_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstFlag |-> $past(rstFlag));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mstWrEn) == '0) |-> ($stable(curOwner) && $stable(curTag)));
endmodule

bind hwmutex_top hwmutex_chk #(.NUM_MASTERS(NUM_MASTERS)) i_chk (
  .clk(clk), .rstN(rstN), .mstWrEn(mstWrEn),
  .curOwner(curOwner), .curTag(curTag), .rstFlag(rstFlag)
);

// File: tb/test_hwmutex_top.sv
module test_hwmutex_top;
  localparam int N = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [N-1:0]      mstWrEn = '0;
  logic [N-1:0]      mstAddr = '0;
  logic [N-1:0][31:0] mstWrData = '0;
  logic [N-1:0][31:0] mstRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    int          port;
    logic [31:0] expVal;
    string       tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #2 clk = ~clk;

  hwmutex_top #(.NUM_MASTERS(N)) i_hwmutex_top (
    .clk(clk), .rstN(rstN), .mstWrEn(mstWrEn), .mstAddr(mstAddr),
    .mstWrData(mstWrData), .mstRdData(mstRdData)
  );

  // monitor: compare read data against expected items, away from the active edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      sbItem_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (mstRdData[it.port] !== it.expVal) begin
        nFails++;
        $display("FAIL %s: port %0d got %h expected %h", it.tag, it.port,
                 mstRdData[it.port], it.expVal);
      end
    end
  end

  task automatic expectRead(input int port, input logic sel, input logic [31:0] expVal,
                            input string tag);
    @(posedge clk); #1;
    mstAddr[port] = sel;
    sbQ.push_back('{port: port, expVal: expVal, tag: tag});
  endtask

  task automatic writeOne(input int port, input logic sel, input logic [31:0] data);
    @(posedge clk); #1;
    mstWrEn[port] = 1'b1; mstAddr[port] = sel; mstWrData[port] = data;
    @(posedge clk); #1;
    mstWrEn = '0;
  endtask

  task automatic writeTwo(input int pa, input logic [31:0] da, input int pb,
                          input logic [31:0] db);
    @(posedge clk); #1;
    mstWrEn[pa] = 1'b1; mstAddr[pa] = 1'b0; mstWrData[pa] = da;
    mstWrEn[pb] = 1'b1; mstAddr[pb] = 1'b0; mstWrData[pb] = db;
    @(posedge clk); #1;
    mstWrEn = '0;
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expectRead(0, 1'b0, 32'h0000_0000, "R1 word");
    expectRead(1, 1'b1, 32'h0000_0001, "R1 flag");
    // R9 write 0 keeps flag, write 1 clears
    writeOne(2, 1'b1, 32'h0000_0000);
    expectRead(2, 1'b1, 32'h0000_0001, "R9 keep");
    writeOne(2, 1'b1, 32'h0000_0001);
    expectRead(2, 1'b1, 32'h0000_0000, "R9 clear");
    // R7 zero-tag write while free
    writeOne(0, 1'b0, 32'h0010_0000);
    expectRead(0, 1'b0, 32'h0000_0000, "R7 free");
    // R3 claim
    writeOne(1, 1'b0, 32'h0011_0005);
    expectRead(1, 1'b0, 32'h0011_0005, "R3 claim");
    // R2 visible on another port
    expectRead(2, 1'b0, 32'h0011_0005, "R2 shared read");
    // R4 other id refused
    writeOne(0, 1'b0, 32'h0010_0007);
    expectRead(0, 1'b0, 32'h0011_0005, "R4 refused");
    // R5 owner updates tag
    writeOne(1, 1'b0, 32'h0011_0009);
    expectRead(1, 1'b0, 32'h0011_0009, "R5 update");
    // R7 release by non-owner
    writeOne(2, 1'b0, 32'h0012_0000);
    expectRead(2, 1'b0, 32'h0011_0009, "R7 foreign release");
    // R6 release by owner
    writeOne(1, 1'b0, 32'h0011_0000);
    expectRead(0, 1'b0, 32'h0000_0000, "R6 release");
    // R8 simultaneous claims, port 0 wins
    writeTwo(0, 32'h0010_0001, 2, 32'h0012_0002);
    expectRead(2, 1'b0, 32'h0010_0001, "R8 low wins");
    // R8 port 0 release evaluated, port 1 claim discarded
    writeTwo(0, 32'h0010_0000, 1, 32'h0011_0003);
    expectRead(1, 1'b0, 32'h0000_0000, "R8 discard");
    // R8 port 1 owner update lost to failing port 0 write
    writeOne(1, 1'b0, 32'h0011_0004);
    writeTwo(0, 32'h0010_0008, 1, 32'h0011_0006);
    expectRead(1, 1'b0, 32'h0011_0004, "R8 lower evaluated");
    // R9 flag stays clear, then reset sets it again (R1)
    expectRead(0, 1'b1, 32'h0000_0000, "R9 sticky clear");
    doReset();
    expectRead(0, 1'b0, 32'h0000_0000, "R1 word after reset");
    expectRead(0, 1'b1, 32'h0000_0001, "R1 flag after reset");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule